// File: doc/BRIEF.md
# Coprocessor Host Control Interface

This block is the byte-wide register window that a host CPU uses to drive a graphics and maths coprocessor. The host reaches sixteen 16-bit general registers and a small set of control registers through an 8-bit data bus. The block also sequences the run state of the coprocessor core. Writing the upper byte of the program counter (the last general register) launches the core. The host can halt the core by clearing the run bit. The core halts itself by pulsing a stop strobe, which raises an interrupt flag for the host.

The execution core itself is outside this block. It appears as a stop strobe, four live arithmetic flags and its current cache line base. In return, the block gives the core a start pulse, a run level and the program counter value. It also drives ownership selects for the shared cartridge ROM and RAM buses, along with a clock-rate select and a multiplier speed select.

Reads are combinational from the address. A read strobe matters only for the side effect on the interrupt flag. Every write takes effect on the next rising clock edge.

Top module: `copro_host_if`

## Requirements
- R1: General register n (n = 0..15) sits at offsets 0x00+2n (low byte) and 0x01+2n (high byte) from base 0x3000. Every byte reads back the last value written and reads 0x00 after reset.
- R2: A write to 0x301F (high byte of register 15) sets the run bit (status low byte 0x3030, bit 5). In the following cycle `core_start` is high for exactly one cycle, and `core_pc` carries the new 16-bit register 15 value.
- R3: A write to 0x3030 with data bit 5 = 0 clears the run bit and does not raise the interrupt flag. A write with bit 5 = 1 leaves the run bit unchanged, so only the R15 high-byte write can start the core.
- R4: A `core_stop` pulse while running clears the run bit and sets the interrupt flag (status high byte 0x3031, bit 7) on the next edge. A `core_stop` pulse while idle changes nothing.
- R5: `host_irq` is high while the interrupt flag is set and config register 0x3037 bit 7 is 0. Setting that bit hides the line but leaves the flag readable.
- R6: A host read of 0x3031 returns the flag and clears it on that edge. If a stop occurs in the same cycle, the flag stays set.
- R7: Status low byte bits 4..1 show the live core flags `core_flags[3:0]` (bit 1 zero, bit 2 carry, bit 3 sign, bit 4 overflow). Bits 7, 6 and 0 read 0.
- R8: Screen mode register 0x303A bit 3 drives `ram_to_core` and bit 4 drives `rom_to_core` (1 gives the bus to the coprocessor, 0 to the host).
- R9: Registers 0x3034, 0x3037, 0x3038, 0x3039 and 0x303A read back all 8 written bits and reset to 0x00. 0x3039 bit 0 drives `clk_double`, and 0x3037 bit 5 drives `mult_fast`.
- R10: 0x303E returns `{core_cache_line[3:0], 4'h0}` and 0x303F returns `core_cache_line[11:4]`. 0x303B returns the VERSION parameter. Writes to these three addresses have no effect.
- R11: Undecoded addresses in the window (for example 0x3032, 0x3035, 0x303D) read 0x00 and ignore writes. A write to 0x3031 does not touch the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_rdata | output | 8 | Read data for the addressed byte |
| core_stop | input | 1 | Core executed its stop opcode |
| core_flags | input | 4 | Live overflow, sign, carry and zero flags |
| core_cache_line | input | 12 | Cache base bits 15..4 from the core |
| core_go | output | 1 | Core run level |
| core_start | output | 1 | One-cycle launch pulse |
| core_pc | output | 16 | Program counter register value |
| host_irq | output | 1 | Host interrupt request, active high |
| ram_to_core | output | 1 | Shared RAM owned by the coprocessor |
| rom_to_core | output | 1 | Shared ROM owned by the coprocessor |
| clk_double | output | 1 | Double clock rate select |
| mult_fast | output | 1 | High-speed multiplier select |

## Verification
The hardest situation to reach is a collision on the interrupt flag: a core stop arriving in the same cycle as the host read that would clear the flag. The flag must survive. The stimulus builds this case directly: it starts the core, then raises `core_stop` and a read of 0x3031 on the same clock edge. It follows with a second, clean read that shows the flag cleared. Masked stops, stops while idle, and an attempt to start through the status run bit are driven the same way. Constrained-random byte traffic covers the register file and the control registers.

// File: rtl/chi_pkg.sv
package chi_pkg;
  // Control window offsets relative to the block base address
  localparam logic [7:0] OFS_STAT_LO = 8'h30;
  localparam logic [7:0] OFS_STAT_HI = 8'h31;
  localparam logic [7:0] OFS_PBANK   = 8'h34;
  localparam logic [7:0] OFS_CFG     = 8'h37;
  localparam logic [7:0] OFS_SBASE   = 8'h38;
  localparam logic [7:0] OFS_CLK     = 8'h39;
  localparam logic [7:0] OFS_MODE    = 8'h3A;
  localparam logic [7:0] OFS_VER     = 8'h3B;
  localparam logic [7:0] OFS_CB_LO   = 8'h3E;
  localparam logic [7:0] OFS_CB_HI   = 8'h3F;

  // Storage slots of the writable control bytes
  typedef enum logic [2:0] {
    CR_PBANK = 3'd0,
    CR_CFG   = 3'd1,
    CR_SBASE = 3'd2,
    CR_CLK   = 3'd3,
    CR_MODE  = 3'd4
  } ctrl_slot_e;
  localparam int NUM_CTRL = 5;

  // Bit positions the block behaviour depends on
  localparam int GO_BIT       = 5;
  localparam int IRQ_MASK_BIT = 7;
  localparam int MULT_BIT     = 5;
  localparam int RAM_OWN_BIT  = 3;
  localparam int ROM_OWN_BIT  = 4;
endpackage

// File: rtl/chi_gpr_file.sv
module chi_gpr_file #(
  parameter int NUM  = 16,
  parameter int IDXW = $clog2(NUM)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_hi,
  input  logic [7:0]      wr_data,
  input  logic [IDXW-1:0] rd_idx,
  input  logic            rd_hi,
  output logic [7:0]      rd_data,
  output logic [15:0]     last_q
);
  logic [15:0] gpr_q [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_reg
    logic        en;
    logic [15:0] d;
    logic [15:0] q;

    always_comb begin
      en = wr_en && (wr_idx == IDXW'(i));
      d  = q;
      if (wr_hi) d[15:8] = wr_data;
      else       d[7:0]  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign gpr_q[i] = q;
  end

  logic [15:0] sel_word;
  always_comb begin
    sel_word = gpr_q[rd_idx];
    rd_data  = rd_hi ? sel_word[15:8] : sel_word[7:0];
  end

  assign last_q = gpr_q[NUM-1];
endmodule

// File: rtl/chi_ctrl_regs.sv
module chi_ctrl_regs
  import chi_pkg::*;
#(
  parameter int N = NUM_CTRL
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       wsel,
  input  logic [7:0]         wdata,
  output logic [N-1:0][7:0]  q
);
  for (genvar i = 0; i < N; i++) begin : g_byte
    logic [7:0] d;
    logic [7:0] r;
    always_comb d = wsel[i] ? wdata : r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else        r <= d;
    end
    assign q[i] = r;
  end
endmodule

// File: rtl/chi_run_ctrl.sv
module chi_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic go_wr,
  input  logic go_wbit,
  input  logic stat_rd,
  input  logic core_stop,
  output logic go_q,
  output logic irq_q,
  output logic start_q
);
  logic go_d, irq_d;

  always_comb begin
    go_d = go_q;
    if (start_wr)                 go_d = 1'b1;
    else if (go_wr && !go_wbit)   go_d = 1'b0;
    else if (core_stop)           go_d = 1'b0;

    irq_d = irq_q;
    if (core_stop && go_q)        irq_d = 1'b1;
    else if (stat_rd)             irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      go_q    <= go_d;
      irq_q   <= irq_d;
      start_q <= start_wr;
    end
  end
endmodule

// File: rtl/copro_host_if.sv
module copro_host_if
  import chi_pkg::*;
#(
  parameter int          NUM_GPR   = 16,
  parameter logic [15:0] BASE_ADDR = 16'h3000,
  parameter logic [7:0]  VERSION   = 8'h04
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] host_addr,
  input  logic [7:0]  host_wdata,
  input  logic        host_wr,
  input  logic        host_rd,
  output logic [7:0]  host_rdata,
  input  logic        core_stop,
  input  logic [3:0]  core_flags,
  input  logic [11:0] core_cache_line,
  output logic        core_go,
  output logic        core_start,
  output logic [15:0] core_pc,
  output logic        host_irq,
  output logic        ram_to_core,
  output logic        rom_to_core,
  output logic        clk_double,
  output logic        mult_fast
);
  localparam int          IDXW      = $clog2(NUM_GPR);
  localparam logic [15:0] GPR_BYTES = 16'(2 * NUM_GPR);

  logic [15:0] off;
  logic        in_ctrl, in_gpr;
  logic [7:0]  ofs8;
  logic        gpr_wr, start_wr, go_wr, stat_rd;
  logic [NUM_CTRL-1:0] ctrl_wsel;
  logic [NUM_CTRL-1:0][7:0] ctrl_q;
  logic [7:0]  gpr_rdata;
  logic        go_q, irq_flag, start_q;

  // ---------------- decode ----------------
  always_comb begin
    off     = host_addr - BASE_ADDR;
    in_ctrl = (off[15:8] == 8'h00);
    ofs8    = off[7:0];
    in_gpr  = (off < GPR_BYTES);
    gpr_wr  = host_wr && in_gpr;
    start_wr = gpr_wr && off[0] && (off[IDXW:1] == IDXW'(NUM_GPR - 1));
    go_wr   = host_wr && in_ctrl && (ofs8 == OFS_STAT_LO);
    stat_rd = host_rd && in_ctrl && (ofs8 == OFS_STAT_HI);
    ctrl_wsel = '0;
    if (host_wr && in_ctrl) begin
      case (ofs8)
        OFS_PBANK: ctrl_wsel[CR_PBANK] = 1'b1;
        OFS_CFG:   ctrl_wsel[CR_CFG]   = 1'b1;
        OFS_SBASE: ctrl_wsel[CR_SBASE] = 1'b1;
        OFS_CLK:   ctrl_wsel[CR_CLK]   = 1'b1;
        OFS_MODE:  ctrl_wsel[CR_MODE]  = 1'b1;
        default:   ctrl_wsel = '0;
      endcase
    end
  end

  // ---------------- storage ----------------
  chi_gpr_file #(.NUM(NUM_GPR), .IDXW(IDXW)) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (gpr_wr),
    .wr_idx  (off[IDXW:1]),
    .wr_hi   (off[0]),
    .wr_data (host_wdata),
    .rd_idx  (off[IDXW:1]),
    .rd_hi   (off[0]),
    .rd_data (gpr_rdata),
    .last_q  (core_pc)
  );

  chi_ctrl_regs #(.N(NUM_CTRL)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wsel  (ctrl_wsel),
    .wdata (host_wdata),
    .q     (ctrl_q)
  );

  chi_run_ctrl u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_wr  (start_wr),
    .go_wr     (go_wr),
    .go_wbit   (host_wdata[GO_BIT]),
    .stat_rd   (stat_rd),
    .core_stop (core_stop),
    .go_q      (go_q),
    .irq_q     (irq_flag),
    .start_q   (start_q)
  );

  // ---------------- read mux ----------------
  always_comb begin
    host_rdata = 8'h00;
    if (in_gpr) begin
      host_rdata = gpr_rdata;
    end else if (in_ctrl) begin
      case (ofs8)
        OFS_STAT_LO: host_rdata = {2'b00, go_q, core_flags, 1'b0};
        OFS_STAT_HI: host_rdata = {irq_flag, 7'b0};
        OFS_PBANK:   host_rdata = ctrl_q[CR_PBANK];
        OFS_CFG:     host_rdata = ctrl_q[CR_CFG];
        OFS_SBASE:   host_rdata = ctrl_q[CR_SBASE];
        OFS_CLK:     host_rdata = ctrl_q[CR_CLK];
        OFS_MODE:    host_rdata = ctrl_q[CR_MODE];
        OFS_VER:     host_rdata = VERSION;
        OFS_CB_LO:   host_rdata = {core_cache_line[3:0], 4'h0};
        OFS_CB_HI:   host_rdata = core_cache_line[11:4];
        default:     host_rdata = 8'h00;
      endcase
    end
  end

  // ---------------- outputs ----------------
  assign core_go     = go_q;
  assign core_start  = start_q;
  assign host_irq    = irq_flag && !ctrl_q[CR_CFG][IRQ_MASK_BIT];
  assign ram_to_core = ctrl_q[CR_MODE][RAM_OWN_BIT];
  assign rom_to_core = ctrl_q[CR_MODE][ROM_OWN_BIT];
  assign clk_double  = ctrl_q[CR_CLK][0];
  assign mult_fast   = ctrl_q[CR_CFG][MULT_BIT];
endmodule

// File: rtl/chi_checker.sv
module chi_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start_wr,
  input logic        go_wr,
  input logic [7:0]  host_wdata,
  input logic        stat_rd,
  input logic        core_stop,
  input logic        core_go,
  input logic        core_start,
  input logic        irq_flag,
  input logic [15:0] host_addr,
  input logic [7:0]  host_rdata
);
  // R2: launch write raises run level and start pulse
  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (core_go && core_start));

  // R3: run level can only rise through the launch write
  a_r3_rise_only_by_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_go) |-> $past(start_wr));

  // R3: clearing run bit halts and leaves the flag alone
  a_r3_host_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && !host_wdata[5] && !start_wr) |=> (!core_go && $stable(irq_flag)));

  // R4: stop while running sets the flag
  a_r4_stop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (core_go && core_stop) |=> irq_flag);

  // R4: flag never rises without a stop while running
  a_r4_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(core_stop && core_go));

  // R6: status read clears unless a stop collides
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(core_stop && core_go)) |=> !irq_flag);

  // R10: cache base low nibble always reads zero
  a_r10_cache_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 16'h303E) |-> (host_rdata[3:0] == 4'h0));
endmodule

bind copro_host_if chi_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_wr   (start_wr),
  .go_wr      (go_wr),
  .host_wdata (host_wdata),
  .stat_rd    (stat_rd),
  .core_stop  (core_stop),
  .core_go    (core_go),
  .core_start (core_start),
  .irq_flag   (irq_flag),
  .host_addr  (host_addr),
  .host_rdata (host_rdata)
);

// File: tb/copro_host_if_bench.sv
`timescale 1ns/100ps
module copro_host_if_bench;
  localparam logic [7:0] VER = 8'h04;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] host_addr = 16'h0000;
  logic [7:0]  host_wdata = 8'h00;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic        core_stop = 1'b0;
  logic [3:0]  core_flags = 4'h0;
  logic [11:0] core_cache_line = 12'h000;
  logic        core_go, core_start, host_irq;
  logic        ram_to_core, rom_to_core, clk_double, mult_fast;
  logic [15:0] core_pc;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  copro_host_if #(.VERSION(VER)) u_copro_host_if (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .core_stop(core_stop), .core_flags(core_flags), .core_cache_line(core_cache_line),
    .core_go(core_go), .core_start(core_start), .core_pc(core_pc), .host_irq(host_irq),
    .ram_to_core(ram_to_core), .rom_to_core(rom_to_core),
    .clk_double(clk_double), .mult_fast(mult_fast));

  // bench model
  logic [15:0] m_gpr [16];
  logic [7:0]  m_ctl [int];

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_gpr(int a);
    int idx = (a - 16'h3000) / 2;
    return (a % 2) ? m_gpr[idx][15:8] : m_gpr[idx][7:0];
  endfunction

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] v);
    @(negedge clk); host_addr = a; host_rd = 1'b1; #1 v = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic stop_pulse();
    @(negedge clk); core_stop = 1'b1;
    @(negedge clk); core_stop = 1'b0;
  endtask

  task automatic gpr_wr(int idx, bit hi, logic [7:0] d);
    wr(16'h3000 + 16'(2*idx) + 16'(hi), d);
    if (hi) m_gpr[idx][15:8] = d; else m_gpr[idx][7:0] = d;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    int addrs [5] = '{'h3034, 'h3037, 'h3038, 'h3039, 'h303A};
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) m_gpr[i] = 16'h0;
    foreach (addrs[k]) m_ctl[addrs[k]] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(16'h301E, v); check("R1 reset gpr", v, 8'h00);
    rd(16'h3037, v); check("R9 reset cfg", v, 8'h00);
    check("R2 reset go", core_go, 0);
    check("R5 reset irq", host_irq, 0);
    check("R8 reset owners", {ram_to_core, rom_to_core}, 2'b00);

    // R3: run bit write of 1 cannot start
    wr(16'h3030, 8'h20);
    check("R3 go-bit write no start", core_go, 0);

    // R1: random register traffic
    for (int n = 0; n < 80; n++) begin
      int idx = $urandom % 16;
      bit hi = $urandom % 2;
      if (idx == 15) hi = 0;
      gpr_wr(idx, hi, 8'($urandom));
    end
    for (int a = 'h3000; a < 'h301F; a++) begin
      rd(16'(a), v); check("R1 gpr readback", v, exp_gpr(a));
    end
    check("R1 no start from traffic", core_go, 0);

    // R2: launch
    gpr_wr(15, 0, 8'h34);
    gpr_wr(15, 1, 8'h12);
    check("R2 start pulse", core_start, 1);
    check("R2 go", core_go, 1);
    check("R2 pc", core_pc, 16'h1234);
    @(negedge clk);
    check("R2 start one cycle", core_start, 0);
    rd(16'h3030, v); check("R2 status go bit", v[5], 1);

    // R3: host halt
    wr(16'h3030, 8'h00);
    check("R3 host halt", core_go, 0);
    rd(16'h3031, v); check("R3 halt no flag", v, 8'h00);

    // R4: stop while idle ignored
    stop_pulse();
    rd(16'h3031, v); check("R4 idle stop ignored", v, 8'h00);

    // R4/R5/R6: stop while running
    gpr_wr(15, 1, 8'h12);
    stop_pulse();
    check("R4 stop halts", core_go, 0);
    check("R5 irq line", host_irq, 1);
    rd(16'h3031, v); check("R6 read shows flag", v, 8'h80);
    check("R6 cleared after read", host_irq, 0);
    rd(16'h3031, v); check("R6 reads zero", v, 8'h00);

    // R5: mask
    wr(16'h3037, 8'h80); m_ctl['h3037] = 8'h80;
    gpr_wr(15, 1, 8'h12);
    stop_pulse();
    check("R5 masked line", host_irq, 0);
    wr(16'h3031, 8'h00);
    wr(16'h3037, 8'h00); m_ctl['h3037] = 8'h00;
    check("R5 unmask shows line", host_irq, 1);
    check("R11 write 3031 keeps flag", host_irq, 1);
    rd(16'h3031, v);

    // R6: collision of stop and read
    gpr_wr(15, 1, 8'h12);
    @(negedge clk); host_addr = 16'h3031; host_rd = 1'b1; core_stop = 1'b1;
    @(negedge clk); host_rd = 1'b0; core_stop = 1'b0;
    check("R6 collision keeps flag", host_irq, 1);
    rd(16'h3031, v); check("R6 collision flag read", v, 8'h80);
    check("R6 clean read clears", host_irq, 0);

    // R7: live flags
    for (int n = 0; n < 6; n++) begin
      core_flags = 4'($urandom);
      rd(16'h3030, v);
      check("R7 status flags", v, {3'b000, core_flags, 1'b0});
    end

    // R8/R9: control bytes
    for (int n = 0; n < 30; n++) begin
      int k = $urandom % 5;
      logic [7:0] d = 8'($urandom);
      if (addrs[k] == 'h3037) d[7] = 1'b0;
      wr(16'(addrs[k]), d); m_ctl[addrs[k]] = d;
      check("R8 ram owner", ram_to_core, m_ctl['h303A][3]);
      check("R8 rom owner", rom_to_core, m_ctl['h303A][4]);
      check("R9 clk select", clk_double, m_ctl['h3039][0]);
      check("R9 mult select", mult_fast, m_ctl['h3037][5]);
    end
    foreach (addrs[k]) begin
      rd(16'(addrs[k]), v); check("R9 ctrl readback", v, m_ctl[addrs[k]]);
    end
    wr(16'h303A, 8'h18);
    check("R8 both to core", {ram_to_core, rom_to_core}, 2'b11);

    // R10: read-only registers
    core_cache_line = 12'hABC;
    wr(16'h303E, 8'hFF); wr(16'h303F, 8'h00); wr(16'h303B, 8'hFF);
    rd(16'h303E, v); check("R10 cache lo", v, 8'hC0);
    rd(16'h303F, v); check("R10 cache hi", v, 8'hAB);
    rd(16'h303B, v); check("R10 version", v, VER);

    // R11: undecoded
    wr(16'h3032, 8'hFF); rd(16'h3032, v); check("R11 3032", v, 8'h00);
    wr(16'h3035, 8'hFF); rd(16'h3035, v); check("R11 3035", v, 8'h00);
    wr(16'h303D, 8'hFF); rd(16'h303D, v); check("R11 303D", v, 8'h00);
    rd(16'h3038, v); check("R11 neighbours intact", v, m_ctl['h3038]);

    done = 1;
    finish_run();
  end
endmodule